// File: doc/BRIEF.md
# PCM Highway Transmit Slot Output Control

This block sits at the upstream end of up to four serial PCM highway ports. For every bit period it decides, for each port, whether the transmit line carries switched voice or signalling data, a programmed idle pattern, or nothing at all (driver off). A frame timing generator supplies a one-cycle strobe at each transmit bit boundary and the bit number within the current slot. The switching side supplies, for each port, whether the current slot is connected and which data bit belongs there. A configuration side supplies a per-port map that picks idle pattern or high impedance separately for each pair of bits in an unconnected slot.

The block registers transmit data, an output enable and an active-low driver-control strobe per port. Because all three outputs of a bit come from the same register stage, data and enable change together. An external bus buffer can be steered directly from the strobe, and several devices can share one highway. A standby input switches every port's driver off at the next bit boundary. Timing and data handling go on unchanged, so on release the next bit boundary already carries the correct content for its slot and bit position.

Top module: `pcm_tx_slot_ctrl`

## Requirements
- R1: After reset every port has `tx_oe` = 0, `txd` = 0 and `tsc_n` = 1 until the first bit strobe.
- R2: At a bit strobe with standby low, a port whose `slot_conn` bit is 1 gets `tx_oe` = 1 and `txd` equal to its `sw_bit` from that strobe cycle.
- R3: At a bit strobe with standby low, a port whose slot is unconnected uses the map bit `idle_map[port][bit_pos / 2]` (two-bit granularity). A 1 drives the idle pattern with `tx_oe` = 1. A 0 leaves the driver off with `tx_oe` = 0.
- R4: Idle output for bit position n is `idle_pat[n]`. The 8-bit pattern is common to all ports, and bit position 7 is the first bit of a slot, so the pattern goes out most significant bit first.
- R5: `tsc_n` of each port is 0 exactly when that port's `tx_oe` is 1.
- R6: A bit strobe that sees `standby` = 1 sets `tx_oe` = 0, `txd` = 0 and `tsc_n` = 1 on every port.
- R7: The first bit strobe that sees `standby` = 0 again produces the output given by R2 to R4 for that strobe's own inputs, with no wait for a frame start.
- R8: Outputs change only on a clock edge where `bit_tick` is 1.
- R9: `txd` is 0 whenever `tx_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each transmit bit boundary |
| bit_pos | input | 3 | Bit number within the slot, 7 sent first, 0 last |
| standby | input | 1 | Forces all transmit drivers off while high |
| slot_conn | input | 4 | Per port: current slot has a connection |
| sw_bit | input | 4 | Per port: switched data bit for this position |
| idle_map | input | 4x4 | Per port, per bit pair: 1 idle pattern, 0 high impedance |
| idle_pat | input | 8 | Shared idle pattern, bit n for position n |
| txd | output | 4 | Transmit data per port |
| tx_oe | output | 4 | Driver enable per port |
| tsc_n | output | 4 | Active-low driver-control strobe per port |

## Verification
A wrong bit-pair selection or idle-bit index in this block shows up on `txd` or `tx_oe` one clock after the strobe of the affected bit position. The bench varies maps and patterns so that each pair boundary is crossed often. A standby state latched wrongly would leave ports driving, or silent, for a whole bit period, and the check at the first strobe after release catches that. A strobe and enable pair that drift apart would put two devices on the same highway at once, and every sampled bit compares the two outputs.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
    // Per-lane decision for one bit period
    typedef struct packed {
        logic drive;
        logic data;
    } lane_out_t;
endpackage

// File: rtl/pcm_idle_sel.sv
module pcm_idle_sel #(
    parameter int SLOT_BITS = 8,
    parameter int PAIR_BITS = 2,
    localparam int BIT_W  = $clog2(SLOT_BITS),
    localparam int PAIRS  = SLOT_BITS / PAIR_BITS,
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int SHIFT  = $clog2(PAIR_BITS)
) (
    input  logic [BIT_W-1:0]     bit_pos,
    input  logic [SLOT_BITS-1:0] idle_pat,
    output logic                 idle_bit,
    output logic [PAIR_W-1:0]    pair_idx
);
    logic [BIT_W-1:0] shifted;

    always_comb begin
        idle_bit = idle_pat[bit_pos];
        shifted  = bit_pos >> SHIFT;
        pair_idx = shifted[PAIR_W-1:0];
    end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_tx_pkg::*;
#(
    parameter int PAIRS = 4,
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              standby,
    input  logic              conn,
    input  logic              sw_bit,
    input  logic [PAIRS-1:0]  pair_map,
    input  logic [PAIR_W-1:0] pair_idx,
    input  logic              idle_bit,
    output lane_out_t         lane
);
    always_comb begin
        lane = '0;
        if (standby) begin
            lane = '0;
        end else if (conn) begin
            lane.drive = 1'b1;
            lane.data  = sw_bit;
        end else if (pair_map[pair_idx]) begin
            lane.drive = 1'b1;
            lane.data  = idle_bit;
        end
    end
endmodule

// File: rtl/pcm_tx_slot_ctrl.sv
module pcm_tx_slot_ctrl
    import pcm_tx_pkg::*;
#(
    parameter int NPORTS    = 4,
    parameter int SLOT_BITS = 8,
    parameter int PAIR_BITS = 2,
    localparam int BIT_W  = $clog2(SLOT_BITS),
    localparam int PAIRS  = SLOT_BITS / PAIR_BITS,
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_tick,
    input  logic [BIT_W-1:0]             bit_pos,
    input  logic                         standby,
    input  logic [NPORTS-1:0]            slot_conn,
    input  logic [NPORTS-1:0]            sw_bit,
    input  logic [NPORTS-1:0][PAIRS-1:0] idle_map,
    input  logic [SLOT_BITS-1:0]         idle_pat,
    output logic [NPORTS-1:0]            txd,
    output logic [NPORTS-1:0]            tx_oe,
    output logic [NPORTS-1:0]            tsc_n
);
    typedef struct packed {
        logic [NPORTS-1:0] txd;
        logic [NPORTS-1:0] oe;
        logic [NPORTS-1:0] tsc_n;
    } out_state_t;

    out_state_t st_d, st_q;

    logic              idle_bit;
    logic [PAIR_W-1:0] pair_idx;
    lane_out_t         lane [NPORTS];

    pcm_idle_sel #(
        .SLOT_BITS(SLOT_BITS),
        .PAIR_BITS(PAIR_BITS)
    ) u_idle (
        .bit_pos (bit_pos),
        .idle_pat(idle_pat),
        .idle_bit(idle_bit),
        .pair_idx(pair_idx)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_lane
        pcm_tx_lane #(.PAIRS(PAIRS)) u_lane (
            .standby (standby),
            .conn    (slot_conn[p]),
            .sw_bit  (sw_bit[p]),
            .pair_map(idle_map[p]),
            .pair_idx(pair_idx),
            .idle_bit(idle_bit),
            .lane    (lane[p])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bit_tick) begin
            for (int p = 0; p < NPORTS; p++) begin
                st_d.oe[p]    = lane[p].drive;
                st_d.txd[p]   = lane[p].drive & lane[p].data;
                st_d.tsc_n[p] = ~lane[p].drive;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.txd   <= '0;
            st_q.oe    <= '0;
            st_q.tsc_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd   = st_q.txd;
    assign tx_oe = st_q.oe;
    assign tsc_n = st_q.tsc_n;

    // Assertions next to the output register
    assert_strobe_matches_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tsc_n == ~tx_oe);

    assert_quiet_line_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (txd & ~tx_oe) == '0);

    assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(txd) && $stable(tx_oe) && $stable(tsc_n)));

    assert_standby_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && standby) |=> (tx_oe == '0 && tsc_n == '1));

    assert_connected_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !standby) |=> ((tx_oe & $past(slot_conn)) == $past(slot_conn)
                                    && (txd & $past(slot_conn)) == ($past(sw_bit) & $past(slot_conn))));
endmodule

// File: tb/pcm_tx_slot_ctrl_test.sv
module pcm_tx_slot_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic [2:0] bit_pos = '0;
    logic standby = 1'b0;
    logic [NP-1:0] slot_conn = '0;
    logic [NP-1:0] sw_bit = '0;
    logic [NP-1:0][3:0] idle_map = '0;
    logic [7:0] idle_pat = '0;
    logic [NP-1:0] txd, tx_oe, tsc_n;

    logic [NP-1:0] exp_d = '0, exp_oe = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_tx_slot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bit_pos(bit_pos),
        .standby(standby), .slot_conn(slot_conn), .sw_bit(sw_bit),
        .idle_map(idle_map), .idle_pat(idle_pat),
        .txd(txd), .tx_oe(tx_oe), .tsc_n(tsc_n)
    );

    // Expected per-port decision from the requirements (R2, R3, R4, R6)
    function automatic logic [1:0] model(input int p);
        logic en, d;
        if (standby) begin en = 0; d = 0; end
        else if (slot_conn[p]) begin en = 1; d = sw_bit[p]; end
        else if (idle_map[p][bit_pos/2]) begin en = 1; d = idle_pat[bit_pos]; end
        else begin en = 0; d = 0; end
        return {en, d};
    endfunction

    task automatic check(input string req);
        for (int p = 0; p < NP; p++) begin
            checks++;
            if (tx_oe[p] !== exp_oe[p] || txd[p] !== exp_d[p] || tsc_n[p] !== ~exp_oe[p]) begin
                fails++;
                $display("FAIL %s port %0d: oe=%b txd=%b tsc_n=%b expected oe=%b txd=%b tsc_n=%b",
                         req, p, tx_oe[p], txd[p], tsc_n[p], exp_oe[p], exp_d[p], ~exp_oe[p]);
            end
        end
    endtask

    // Inputs already driven at a falling edge; clock once and check at next falling edge
    task automatic step(input string req);
        if (bit_tick) begin
            for (int p = 0; p < NP; p++) begin
                logic [1:0] m;
                m = model(p);
                exp_oe[p] = m[1];
                exp_d[p]  = m[0];
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset release");

        // Directed: idle pattern sweep over every bit position, MSB first (R3, R4)
        idle_pat = 8'b1011_0010;
        idle_map = {4'b1111, 4'b0101, 4'b1010, 4'b0000};
        slot_conn = '0;
        for (int b = 7; b >= 0; b--) begin
            bit_pos = 3'(b); bit_tick = 1'b1;
            step("R3 R4 pair map and idle bit");
        end

        // Directed: connected slot overrides idle map (R2)
        slot_conn = 4'b1111; sw_bit = 4'b1010; bit_pos = 3'd3;
        step("R2 connected data");

        // No strobe: outputs hold although inputs change (R8)
        bit_tick = 1'b0; sw_bit = 4'b0101; slot_conn = 4'b0000; idle_map = '0;
        step("R8 hold without strobe");

        // Standby at a strobe (R6), then release mid-slot (R7)
        bit_tick = 1'b1; standby = 1'b1; slot_conn = 4'b1111;
        step("R6 standby");
        bit_tick = 1'b0; standby = 1'b0;
        step("R6 R8 standby held until strobe");
        bit_tick = 1'b1; bit_pos = 3'd5; sw_bit = 4'b0110;
        step("R7 resume at next boundary");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            bit_tick  = ($urandom % 3) != 0;
            bit_pos   = 3'($urandom);
            standby   = ($urandom % 8) == 0;
            slot_conn = 4'($urandom);
            sw_bit    = 4'($urandom);
            idle_map  = 16'($urandom);
            idle_pat  = 8'($urandom);
            step("R2 R3 R5 R6 R7 R8 R9 random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule